// File: doc/BRIEF.md
# Path Overhead Byte Monitor

This block watches the path-level overhead bytes of a SONET/SDH receive path. Once per frame, marked by a one-cycle frame strobe, it receives the signal label byte (C2), the network operator byte (N1) and the APS/spare byte (K3). It also follows two level inputs: the signal-fail and signal-degrade states that an external BER engine computes. It filters N1 and K3 through a persistence check before it accepts a new value, and it compares C2 with a programmed expected label.

Every change or event it detects is latched into a six-bit sticky event register. A mask register selects which latched bits may drive a single registered interrupt. A small register port reads the event register, the mask and the two accepted monitor bytes. Event bits are cleared in one of two ways chosen by a mode input: a read of the event register clears them, or software writes ones to them.

Top module: `poh_monitor`

## Requirements
- R1: After reset the event register, the mask, both monitor bytes, the read data and the interrupt are all zero.
- R2: A C2 byte of 0x00 at a frame strobe sets the unequipped bit (bit 13). It fires only on entry into that condition and not again while the condition persists.
- R3: A C2 byte that differs from expC2 at a frame strobe sets the label-mismatch bit (bit 12), again only on entry. A frame that carries the expected label ends the condition, and a later mismatch fires it again.
- R4: The N1 monitor takes a new byte only after that byte has arrived in n1Persist back-to-back frames. When the monitor changes it sets bit 11.
- R5: The K3 monitor follows the same rule with its own count, k3Persist, and sets bit 10 when it changes.
- R6: A byte that differs from the previous frame's byte restarts the run count at 1. A persistence setting of 0 behaves as 1.
- R7: Any change of sfBerState sets bit 15, and any change of sdBerState sets bit 14, in either direction.
- R8: A read takes effect one cycle after regRd is asserted, on regRdata. Address 0 returns the event register in bits [15:10]. Address 1 returns the mask in bits [15:10]. Address 2 returns {N1 monitor, K3 monitor}. All other bits read as zero. regWdata[5:0] maps to bits 15..10, with bit 5 for SF.
- R9: With clrOnWrite=0, reading address 0 clears the bits it returned. Writes to address 0 have no effect.
- R10: With clrOnWrite=1, writing 1 to a bit at address 0 clears it, and writing 0 leaves it. Reads do not clear.
- R11: An event that arrives in the same cycle as a clear of its bit leaves the bit set.
- R12: irq is a register that holds the OR of the event bits whose mask bit is 0. A masked bit never raises irq.
- R13: Byte inputs in cycles without a frame strobe change neither the monitors nor the event register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStb | input | 1 | One-cycle strobe, overhead bytes valid |
| c2Byte | input | 8 | Received signal label byte |
| n1Byte | input | 8 | Received N1 byte |
| k3Byte | input | 8 | Received K3 byte |
| sfBerState | input | 1 | Signal-fail BER state |
| sdBerState | input | 1 | Signal-degrade BER state |
| expC2 | input | 8 | Expected signal label |
| n1Persist | input | 4 | N1 persistence frame count |
| k3Persist | input | 4 | K3 persistence frame count |
| clrOnWrite | input | 1 | 1: write-one-to-clear, 0: clear on read |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 6 | Write data for event bits 15..10 |
| regRdata | output | 16 | Registered read data |
| irq | output | 1 | Registered interrupt |

## Verification
Assertions check several rules on every cycle. A pending event must appear in the sticky register on the next cycle. Latched bits may be lost only in a cycle that carries a clear for the active mode. The monitors may move only on a frame strobe. Unequipped and mismatch events never fire in two consecutive cycles, and a fully masked register keeps irq low. Some behaviour only the bench scenarios can show: the exact persistence run lengths and restarts, the read-address map, entry-only firing across changing C2 patterns, and the choice of which mode clears a bit.

// File: rtl/poh_pkg.sv
package poh_pkg;
  localparam int EVT_W = 6;

  // event strobes from control to datapath; field order is bit 15 down to bit 10
  typedef struct packed {
    logic sfDelta;
    logic sdDelta;
    logic uneqEvt;
    logic plmEvt;
    logic n1Delta;
    logic k3Delta;
  } pohEvt_t;
endpackage

// File: rtl/poh_persist.sv
module poh_persist #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStb,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic [CNT_W-1:0]  persistCfg,
  output logic [BYTE_W-1:0] monOut,
  output logic              deltaOut
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [BYTE_W-1:0] lastByte;
  logic [CNT_W-1:0]  runCnt, nextCnt, limit;

  always_comb begin
    limit   = (persistCfg == '0) ? CNT_W'(1) : persistCfg;
    nextCnt = (byteIn != lastByte) ? CNT_W'(1)
            : ((runCnt == CNT_MAX) ? runCnt : runCnt + CNT_W'(1));
    deltaOut = frameStb && (nextCnt >= limit) && (byteIn != monOut);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastByte <= '0;
      runCnt   <= '0;
      monOut   <= '0;
    end else if (frameStb) begin
      lastByte <= byteIn;
      runCnt   <= nextCnt;
      if (deltaOut) monOut <= byteIn;
    end
  end

  // R13: monitor never moves without a frame strobe
  a_r13_mon_frame_only: assert property (@(posedge clk) disable iff (!rstN)
    !frameStb |=> $stable(monOut));
  // R4: a monitor update always lands on the byte that was presented
  a_r4_mon_takes_byte: assert property (@(posedge clk) disable iff (!rstN)
    deltaOut |=> (monOut == $past(byteIn)));
endmodule

// File: rtl/poh_detect.sv
module poh_detect
  import poh_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStb,
  input  logic [BYTE_W-1:0] c2Byte,
  input  logic [BYTE_W-1:0] n1Byte,
  input  logic [BYTE_W-1:0] k3Byte,
  input  logic              sfBerState,
  input  logic              sdBerState,
  input  logic [BYTE_W-1:0] expC2,
  input  logic [CNT_W-1:0]  n1Persist,
  input  logic [CNT_W-1:0]  k3Persist,
  output pohEvt_t           evt,
  output logic [BYTE_W-1:0] n1Mon,
  output logic [BYTE_W-1:0] k3Mon
);
  localparam int NUM_MON = 2;

  logic sfPrev, sdPrev, uneqState, plmState;
  logic uneqNow, plmNow;
  logic [NUM_MON-1:0][BYTE_W-1:0] monIn, monOut;
  logic [NUM_MON-1:0][CNT_W-1:0]  monCfg;
  logic [NUM_MON-1:0]             monDelta;

  assign monIn  = {n1Byte, k3Byte};
  assign monCfg = {n1Persist, k3Persist};

  for (genvar g = 0; g < NUM_MON; g++) begin : gMon
    poh_persist #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) uPersist (
      .clk       (clk),
      .rstN      (rstN),
      .frameStb  (frameStb),
      .byteIn    (monIn[g]),
      .persistCfg(monCfg[g]),
      .monOut    (monOut[g]),
      .deltaOut  (monDelta[g])
    );
  end

  assign n1Mon = monOut[1];
  assign k3Mon = monOut[0];

  always_comb begin
    uneqNow     = (c2Byte == '0);
    plmNow      = (c2Byte != expC2);
    evt.sfDelta = (sfBerState != sfPrev);
    evt.sdDelta = (sdBerState != sdPrev);
    evt.uneqEvt = frameStb && uneqNow && !uneqState;
    evt.plmEvt  = frameStb && plmNow && !plmState;
    evt.n1Delta = monDelta[1];
    evt.k3Delta = monDelta[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sfPrev    <= 1'b0;
      sdPrev    <= 1'b0;
      uneqState <= 1'b0;
      plmState  <= 1'b0;
    end else begin
      sfPrev <= sfBerState;
      sdPrev <= sdBerState;
      if (frameStb) begin
        uneqState <= uneqNow;
        plmState  <= plmNow;
      end
    end
  end

  // R2: unequipped fires on entry only
  a_r2_uneq_once: assert property (@(posedge clk) disable iff (!rstN)
    evt.uneqEvt |=> !evt.uneqEvt);
  // R3: mismatch fires on entry only
  a_r3_plm_once: assert property (@(posedge clk) disable iff (!rstN)
    evt.plmEvt |=> !evt.plmEvt);
  // R7: after a delta, another one needs a fresh input change
  a_r7_sf_settles: assert property (@(posedge clk) disable iff (!rstN)
    evt.sfDelta |=> (!evt.sfDelta || (sfBerState != $past(sfBerState))));
endmodule

// File: rtl/poh_regs.sv
module poh_regs
  import poh_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pohEvt_t           evt,
  input  logic [BYTE_W-1:0] n1Mon,
  input  logic [BYTE_W-1:0] k3Mon,
  input  logic              clrOnWrite,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [EVT_W-1:0]  regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq
);
  localparam int EVT_LSB = DATA_W - EVT_W;
  localparam logic [ADDR_W-1:0] ADDR_EVT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_MON  = ADDR_W'(2);

  logic [EVT_W-1:0] evtVec, stickyQ, maskQ, clrVec;
  logic [DATA_W-1:0] rdMux;
  logic evtRd, evtWr;

  assign evtVec = evt;
  assign evtRd  = regRd && (regAddr == ADDR_EVT);
  assign evtWr  = regWr && (regAddr == ADDR_EVT);

  always_comb begin
    if (clrOnWrite) clrVec = evtWr ? regWdata : '0;
    else            clrVec = evtRd ? stickyQ  : '0;
    case (regAddr)
      ADDR_EVT:  rdMux = {stickyQ, {EVT_LSB{1'b0}}};
      ADDR_MASK: rdMux = {maskQ, {EVT_LSB{1'b0}}};
      ADDR_MON:  rdMux = DATA_W'({n1Mon, k3Mon});
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyQ  <= '0;
      maskQ    <= '0;
      regRdata <= '0;
      irq      <= 1'b0;
    end else begin
      stickyQ <= (stickyQ & ~clrVec) | evtVec;
      if (regWr && regAddr == ADDR_MASK) maskQ <= regWdata;
      if (regRd) regRdata <= rdMux;
      irq <= |(stickyQ & ~maskQ);
    end
  end

  // R11: every pending event is latched on the next edge
  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec) |=> ((stickyQ & $past(evtVec)) == $past(evtVec)));
  // R9: in read-clear mode no bit is lost without a read of the event register
  a_r9_cor_no_loss: assert property (@(posedge clk) disable iff (!rstN)
    (!clrOnWrite && !evtRd) |=> ((stickyQ & $past(stickyQ)) == $past(stickyQ)));
  // R10: in write-clear mode no bit is lost without a write to the event register
  a_r10_cow_no_loss: assert property (@(posedge clk) disable iff (!rstN)
    (clrOnWrite && !evtWr) |=> ((stickyQ & $past(stickyQ)) == $past(stickyQ)));
  // R12: fully masked or empty register keeps irq low
  a_r12_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((stickyQ & ~maskQ) == '0) |=> !irq);
endmodule

// File: rtl/poh_monitor.sv
module poh_monitor
  import poh_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStb,
  input  logic [BYTE_W-1:0] c2Byte,
  input  logic [BYTE_W-1:0] n1Byte,
  input  logic [BYTE_W-1:0] k3Byte,
  input  logic              sfBerState,
  input  logic              sdBerState,
  input  logic [BYTE_W-1:0] expC2,
  input  logic [CNT_W-1:0]  n1Persist,
  input  logic [CNT_W-1:0]  k3Persist,
  input  logic              clrOnWrite,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [EVT_W-1:0]  regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq
);
  pohEvt_t evtStb;
  logic [BYTE_W-1:0] n1Mon, k3Mon;

  poh_detect #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) uDetect (
    .clk       (clk),
    .rstN      (rstN),
    .frameStb  (frameStb),
    .c2Byte    (c2Byte),
    .n1Byte    (n1Byte),
    .k3Byte    (k3Byte),
    .sfBerState(sfBerState),
    .sdBerState(sdBerState),
    .expC2     (expC2),
    .n1Persist (n1Persist),
    .k3Persist (k3Persist),
    .evt       (evtStb),
    .n1Mon     (n1Mon),
    .k3Mon     (k3Mon)
  );

  poh_regs #(.BYTE_W(BYTE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evtStb),
    .n1Mon     (n1Mon),
    .k3Mon     (k3Mon),
    .clrOnWrite(clrOnWrite),
    .regRd     (regRd),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .irq       (irq)
  );
endmodule

// File: tb/poh_monitor_bench.sv
`timescale 1ns/1ps
module poh_monitor_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStb = 1'b0;
  logic [7:0] c2Byte = 8'h13, n1Byte = 8'h00, k3Byte = 8'h00, expC2 = 8'h13;
  logic sfBerState = 1'b0, sdBerState = 1'b0;
  logic [3:0] n1Persist = 4'd3, k3Persist = 4'd0;
  logic clrOnWrite = 1'b0, regRd = 1'b0, regWr = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [5:0] regWdata = 6'd0;
  logic [15:0] regRdata;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  poh_monitor u_poh_monitor (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .c2Byte(c2Byte),
    .n1Byte(n1Byte), .k3Byte(k3Byte), .sfBerState(sfBerState),
    .sdBerState(sdBerState), .expC2(expC2), .n1Persist(n1Persist),
    .k3Persist(k3Persist), .clrOnWrite(clrOnWrite), .regRd(regRd),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  // behavioural reference model
  logic [5:0] mSticky, mMask;
  logic [15:0] mRdata;
  logic mIrq, mSfPrev, mSdPrev, mUeq, mPlm;
  int mN1Last, mN1Cnt, mN1Mon, mK3Last, mK3Cnt, mK3Mon;

  always @(posedge clk or negedge rstN) begin
    logic [5:0] ev, clr;
    int lim;
    if (!rstN) begin
      mSticky = 0; mMask = 0; mRdata = 0; mIrq = 0; mSfPrev = 0; mSdPrev = 0;
      mUeq = 0; mPlm = 0; mN1Last = 0; mN1Cnt = 0; mN1Mon = 0;
      mK3Last = 0; mK3Cnt = 0; mK3Mon = 0;
    end else begin
      if (regRd) begin
        if (regAddr == 0) mRdata = {mSticky, 10'b0};
        else if (regAddr == 1) mRdata = {mMask, 10'b0};
        else if (regAddr == 2) mRdata = {mN1Mon[7:0], mK3Mon[7:0]};
        else mRdata = 0;
      end
      mIrq = |(mSticky & ~mMask);
      ev = 0;
      if (sfBerState != mSfPrev) ev[5] = 1;
      if (sdBerState != mSdPrev) ev[4] = 1;
      mSfPrev = sfBerState; mSdPrev = sdBerState;
      if (frameStb) begin
        if (c2Byte == 0 && !mUeq) ev[3] = 1;
        if (c2Byte != expC2 && !mPlm) ev[2] = 1;
        mUeq = (c2Byte == 0); mPlm = (c2Byte != expC2);
        if (int'(n1Byte) != mN1Last) mN1Cnt = 1; else if (mN1Cnt < 15) mN1Cnt++;
        mN1Last = n1Byte;
        lim = (n1Persist == 0) ? 1 : int'(n1Persist);
        if (mN1Cnt >= lim && int'(n1Byte) != mN1Mon) begin mN1Mon = n1Byte; ev[1] = 1; end
        if (int'(k3Byte) != mK3Last) mK3Cnt = 1; else if (mK3Cnt < 15) mK3Cnt++;
        mK3Last = k3Byte;
        lim = (k3Persist == 0) ? 1 : int'(k3Persist);
        if (mK3Cnt >= lim && int'(k3Byte) != mK3Mon) begin mK3Mon = k3Byte; ev[0] = 1; end
      end
      clr = 0;
      if (clrOnWrite && regWr && regAddr == 0) clr = regWdata;
      if (!clrOnWrite && regRd && regAddr == 0) clr = mSticky;
      if (regWr && regAddr == 1) mMask = regWdata;
      mSticky = (mSticky & ~clr) | ev;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (rstN && !done) begin
    checks++;
    if (regRdata !== mRdata) begin
      failures++;
      $display("FAIL R8 model rdata actual=%h expected=%h t=%0t", regRdata, mRdata, $time);
    end
    checks++;
    if (irq !== mIrq) begin
      failures++;
      $display("FAIL R12 model irq actual=%b expected=%b t=%0t", irq, mIrq, $time);
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); regRd = 1; regAddr = a;
    @(negedge clk); regRd = 0;
    chk(tag, regRdata, exp);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk); regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 0;
  endtask

  task automatic frame(input logic [7:0] c2, input logic [7:0] n1, input logic [7:0] k3);
    @(negedge clk); frameStb = 1; c2Byte = c2; n1Byte = n1; k3Byte = k3;
    @(negedge clk); frameStb = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1;
    idle(1);
    chk("R1 rdata", regRdata, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    readReg(0, 16'h0000, "R1 event");
    readReg(1, 16'h0000, "R1 mask");
    readReg(2, 16'h0000, "R1 monitors");
    frame(8'h13, 8'h00, 8'h00);
    frame(8'h13, 8'h00, 8'h00);
    readReg(0, 16'h0000, "R3 matching label");

    // R7 BER state changes
    @(negedge clk); sfBerState = 1;
    readReg(0, 16'h8000, "R7 sf rise");
    readReg(0, 16'h0000, "R9 read cleared");
    @(negedge clk); sdBerState = 1;
    @(negedge clk); sdBerState = 0;
    readReg(0, 16'h4000, "R7 sd both edges");

    // R2 / R3 C2 checks
    frame(8'h00, 8'h00, 8'h00);
    readReg(0, 16'h3000, "R2 unequipped and mismatch");
    frame(8'h00, 8'h00, 8'h00);
    frame(8'h00, 8'h00, 8'h00);
    readReg(0, 16'h0000, "R2 no refire");
    frame(8'h55, 8'h00, 8'h00);
    readReg(0, 16'h0000, "R3 mismatch persists");
    frame(8'h13, 8'h00, 8'h00);
    frame(8'h77, 8'h00, 8'h00);
    readReg(0, 16'h1000, "R3 mismatch reentry");
    frame(8'h13, 8'h00, 8'h00);

    // R4 / R6 N1 persistence
    frame(8'h13, 8'hAA, 8'h00);
    frame(8'h13, 8'hAA, 8'h00);
    readReg(2, 16'h0000, "R4 two frames short");
    frame(8'h13, 8'hAA, 8'h00);
    readReg(2, 16'hAA00, "R4 n1 accepted");
    readReg(0, 16'h0800, "R4 n1 delta");
    frame(8'h13, 8'hBB, 8'h00);
    frame(8'h13, 8'hBB, 8'h00);
    frame(8'h13, 8'hCC, 8'h00);
    frame(8'h13, 8'hBB, 8'h00);
    frame(8'h13, 8'hBB, 8'h00);
    readReg(2, 16'hAA00, "R6 run restarted");
    frame(8'h13, 8'hBB, 8'h00);
    readReg(2, 16'hBB00, "R6 n1 after restart");
    readReg(0, 16'h0800, "R4 second delta");

    // R5 / R6 K3 with count 0
    frame(8'h13, 8'hBB, 8'h5C);
    readReg(2, 16'hBB5C, "R5 k3 count zero");
    readReg(0, 16'h0400, "R5 k3 delta");

    // R13 no strobe
    @(negedge clk); c2Byte = 8'h00; n1Byte = 8'h11; k3Byte = 8'h22;
    idle(5);
    readReg(2, 16'hBB5C, "R13 monitors held");
    readReg(0, 16'h0000, "R13 no events");
    @(negedge clk); c2Byte = 8'h13; n1Byte = 8'hBB; k3Byte = 8'h5C;

    // R12 masking
    writeReg(1, 6'b100000);
    readReg(1, 16'h8000, "R8 mask readback");
    @(negedge clk); sfBerState = 0;
    idle(3);
    chk("R12 masked irq", {15'b0, irq}, 16'h0);
    readReg(0, 16'h8000, "R12 masked bit latched");
    writeReg(1, 6'b000000);
    @(negedge clk); sdBerState = 1;
    idle(3);
    chk("R12 unmasked irq", {15'b0, irq}, 16'h1);
    readReg(0, 16'h4000, "R12 sd bit");
    idle(2);
    chk("R12 irq drops", {15'b0, irq}, 16'h0);

    // R9 writes ignored in read-clear mode
    @(negedge clk); sfBerState = 1;
    writeReg(0, 6'b111111);
    readReg(0, 16'h8000, "R9 write ignored");

    // R11 in read-clear mode
    @(negedge clk); sdBerState = 0;
    @(negedge clk); regRd = 1; regAddr = 0; sdBerState = 1;
    @(negedge clk); regRd = 0;
    chk("R11 read returns old", regRdata, 16'h4000);
    readReg(0, 16'h4000, "R11 event beats read clear");

    // R10 write-clear mode
    clrOnWrite = 1;
    @(negedge clk); sfBerState = 0;
    readReg(0, 16'h8000, "R10 read keeps");
    readReg(0, 16'h8000, "R10 read keeps again");
    writeReg(0, 6'b000000);
    readReg(0, 16'h8000, "R10 zero write keeps");
    writeReg(0, 6'b100000);
    readReg(0, 16'h0000, "R10 one clears");

    // R11 in write-clear mode
    @(negedge clk); sfBerState = 1;
    @(negedge clk); regWr = 1; regAddr = 0; regWdata = 6'b100000; sfBerState = 0;
    @(negedge clk); regWr = 0;
    readReg(0, 16'h8000, "R11 event beats write clear");

    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule